// File: doc/BRIEF.md
# Hidden Configuration Bank Behind a Task-File Port

This block sits on the I/O decode of an IDE-style task-file port (offsets 0 to 7). It normally forwards every access to the drive task file. A fixed run of ordinary accesses opens a small bank of hidden configuration bytes: two 16-bit reads at offset 1, then a byte write of 0x03 to offset 2. While the bank is open, byte accesses at indices 0, 1, 3, 5 and 6 reach the configuration storage instead of the drives. A byte write of 0x83 to offset 2 closes the bank again.

The bank holds per-set read and write cycle timing bytes, a control byte and a miscellaneous byte. It also shows a read-only strap that reports which bus clock was selected. There are two timing sets. Set B can only be reached after a plain, closed-bank byte write of 0xC0 to offset 3, and only when bit 0 of the miscellaneous byte selects it. Reads of the bank come back on the same read-data bus that the task file uses.

The detector is a four-state machine. ST_IDLE moves to ST_ONE_RD on a word read at offset 1. ST_ONE_RD moves to ST_TWO_RD on a second such read. ST_TWO_RD moves to ST_OPEN on the opening key write. ST_OPEN returns to ST_IDLE on the closing key write. Any other access in ST_IDLE, ST_ONE_RD or ST_TWO_RD returns the machine to ST_IDLE.

Top module: `hcfg_bank`

## Requirements
- R1: After reset the bank is closed, every timing byte, the control byte and the miscellaneous byte read 0x00, and `rdata` equals `tf_rdata`.
- R2: The bank opens (`bank_open` high the cycle after) only after a word read at offset 1, a second word read at offset 1, then a byte write of 0x03 to offset 2, with each step as consecutive valid accesses. The opening write itself is not forwarded (`tf_sel` low).
- R3: Any valid access that is not the expected next step (a byte read instead of a word read, a wrong key value, a third word read, a write out of order) returns the detector to ST_IDLE, so the bank stays closed. A full correct sequence afterwards still opens it.
- R4: While the bank is open, a byte write of 0x83 to offset 2 closes it. `bank_open` is low in the next cycle and task-file decoding resumes.
- R5: While the bank is open, `tf_sel` stays low for every access. While it is closed, every valid access asserts `tf_sel`, except the opening write.
- R6: With the bank open, byte writes store data at index 0 (read timing), 1 (write timing), 3 (control, bits on `ctrl_reg`) and 6 (miscellaneous, bits on `misc_reg`). Byte reads at those indices return the stored byte in `rdata[7:0]` with `rdata[15:8]` zero.
- R7: With the bank open, a byte read at index 5 returns `strap_clk25` in bit 0 (1 selects 25 MHz, 0 selects 33 MHz) and zero elsewhere. Writes to index 5 have no effect.
- R8: With the bank open, byte reads at indices 2, 4 and 7 and any word read return 0x0000. Word writes and writes to those indices store nothing.
- R9: A closed-bank byte write of 0xC0 to offset 3 arms set-B access. Any other closed-bank byte write to offset 3 disarms it. Reset leaves it disarmed.
- R10: Timing indices 0 and 1 address set B (`rd_timing[15:8]`, `wr_timing[15:8]`) when set-B access is armed and `misc_reg[0]` is 1. Otherwise they address set A (`rd_timing[7:0]`, `wr_timing[7:0]`).
- R11: While the bank is closed, no access changes any configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An I/O access is present this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| acc_addr | input | 3 | Port offset / configuration index |
| acc_wbyte | input | 8 | Low byte of write data |
| tf_rdata | input | 16 | Read data from the drive task file |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| tf_sel | output | 1 | Access is forwarded to the task file |
| rdata | output | 16 | Read data returned to the host |
| bank_open | output | 1 | Configuration bank is open |
| rd_timing | output | 16 | Read-cycle timing bytes, set A low, set B high |
| wr_timing | output | 16 | Write-cycle timing bytes, set A low, set B high |
| ctrl_reg | output | 8 | Control byte |
| misc_reg | output | 8 | Miscellaneous byte, bit 0 picks the timing set |

## Verification
The bench breaks the unlock run in several ways: a byte read where a word read belongs, a third word read, the wrong key, and a write too early. A detector that only counted offset-1 reads, or that failed to fall back to idle, would open the bank on these. It checks that the opening and closing writes and every open-bank access stay off the task file, because a decoder that forwarded them would fire stray drive commands. It writes set-B timing both before and after the 0xC0 arm write. An ungated set select would corrupt set B, and a missing one would overwrite set A. It also checks that the strap ignores writes and that undefined indices read zero.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ONE_RD,
        ST_TWO_RD,
        ST_OPEN
    } unlock_state_e;

    localparam logic [2:0] IDX_RD_TIM = 3'd0;
    localparam logic [2:0] IDX_WR_TIM = 3'd1;
    localparam logic [2:0] IDX_CTRL   = 3'd3;
    localparam logic [2:0] IDX_STRAP  = 3'd5;
    localparam logic [2:0] IDX_MISC   = 3'd6;

endpackage

// File: rtl/hcfg_unlock_fsm.sv
module hcfg_unlock_fsm
    import hcfg_pkg::*;
#(
    parameter int          ADDR_W    = 3,
    parameter int          BYTE_W    = 8,
    parameter int          RD_OFS    = 1,
    parameter int          GATE_OFS  = 2,
    parameter logic [7:0]  OPEN_KEY  = 8'h03,
    parameter logic [7:0]  CLOSE_KEY = 8'h83
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_word,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BYTE_W-1:0] acc_wbyte,
    output logic              bank_open,
    output logic              key_hit
);

    unlock_state_e state_q, state_d;

    logic is_seq_rd;
    logic is_open_key;
    logic is_close_key;
    logic is_gate_wr;

    assign is_seq_rd    = acc_valid && !acc_write && acc_word
                          && (acc_addr == ADDR_W'(RD_OFS));
    assign is_gate_wr   = acc_valid && acc_write && !acc_word
                          && (acc_addr == ADDR_W'(GATE_OFS));
    assign is_open_key  = is_gate_wr && (acc_wbyte == BYTE_W'(OPEN_KEY));
    assign is_close_key = is_gate_wr && (acc_wbyte == BYTE_W'(CLOSE_KEY));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_valid) state_d = is_seq_rd   ? ST_ONE_RD : ST_IDLE;
            ST_ONE_RD: if (acc_valid) state_d = is_seq_rd   ? ST_TWO_RD : ST_IDLE;
            ST_TWO_RD: if (acc_valid) state_d = is_open_key ? ST_OPEN   : ST_IDLE;
            ST_OPEN:   if (is_close_key) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bank_open = (state_q == ST_OPEN);
        key_hit   = (state_q == ST_TWO_RD) && is_open_key;
    end

endmodule

// File: rtl/hcfg_regbank.sv
module hcfg_regbank
    import hcfg_pkg::*;
#(
    parameter int               REG_W    = 8,
    parameter int               ADDR_W   = 3,
    parameter int               NUM_SETS = 2,
    parameter logic [REG_W-1:0] TIM_RST  = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr,
    input  logic [ADDR_W-1:0]              cfg_idx,
    input  logic [REG_W-1:0]               cfg_wdata,
    input  logic                           arm_load,
    input  logic                           arm_value,
    input  logic                           strap_bit,
    output logic [REG_W-1:0]               cfg_rdata,
    output logic [NUM_SETS-1:0][REG_W-1:0] rd_tim,
    output logic [NUM_SETS-1:0][REG_W-1:0] wr_tim,
    output logic [REG_W-1:0]               ctrl_q,
    output logic [REG_W-1:0]               misc_q
);

    localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

    logic             setb_armed;
    logic [SEL_W-1:0] set_sel;

    always_ff @(posedge clk) begin
        if (!rst_n)        setb_armed <= 1'b0;
        else if (arm_load) setb_armed <= arm_value;
    end

    assign set_sel = setb_armed ? misc_q[SEL_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            misc_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_idx == ADDR_W'(IDX_CTRL)) ctrl_q <= cfg_wdata;
            if (cfg_idx == ADDR_W'(IDX_MISC)) misc_q <= cfg_wdata;
        end
    end

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        logic hit;
        assign hit = cfg_wr && (set_sel == SEL_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_tim[g] <= TIM_RST;
                wr_tim[g] <= TIM_RST;
            end else if (hit) begin
                if (cfg_idx == ADDR_W'(IDX_RD_TIM)) rd_tim[g] <= cfg_wdata;
                if (cfg_idx == ADDR_W'(IDX_WR_TIM)) wr_tim[g] <= cfg_wdata;
            end
        end
    end

    logic [REG_W-1:0] cur_rd;
    logic [REG_W-1:0] cur_wr;

    always_comb begin
        cur_rd = '0;
        cur_wr = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (set_sel == SEL_W'(s)) begin
                cur_rd = rd_tim[s];
                cur_wr = wr_tim[s];
            end
        end
    end

    always_comb begin
        case (cfg_idx)
            ADDR_W'(IDX_RD_TIM): cfg_rdata = cur_rd;
            ADDR_W'(IDX_WR_TIM): cfg_rdata = cur_wr;
            ADDR_W'(IDX_CTRL):   cfg_rdata = ctrl_q;
            ADDR_W'(IDX_STRAP):  cfg_rdata = {{(REG_W-1){1'b0}}, strap_bit};
            ADDR_W'(IDX_MISC):   cfg_rdata = misc_q;
            default:             cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hcfg_bank.sv
module hcfg_bank #(
    parameter int          DATA_W    = 16,
    parameter int          REG_W     = 8,
    parameter int          ADDR_W    = 3,
    parameter int          NUM_SETS  = 2,
    parameter int          RD_OFS    = 1,
    parameter int          GATE_OFS  = 2,
    parameter int          ARM_OFS   = 3,
    parameter logic [7:0]  OPEN_KEY  = 8'h03,
    parameter logic [7:0]  CLOSE_KEY = 8'h83,
    parameter logic [7:0]  ARM_KEY   = 8'hC0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic                      acc_word,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [REG_W-1:0]          acc_wbyte,
    input  logic [DATA_W-1:0]         tf_rdata,
    input  logic                      strap_clk25,
    output logic                      tf_sel,
    output logic [DATA_W-1:0]         rdata,
    output logic                      bank_open,
    output logic [NUM_SETS*REG_W-1:0] rd_timing,
    output logic [NUM_SETS*REG_W-1:0] wr_timing,
    output logic [REG_W-1:0]          ctrl_reg,
    output logic [REG_W-1:0]          misc_reg
);

    logic                           key_hit;
    logic                           cfg_wr;
    logic                           arm_load;
    logic [REG_W-1:0]               cfg_rdata;
    logic [NUM_SETS-1:0][REG_W-1:0] rd_tim;
    logic [NUM_SETS-1:0][REG_W-1:0] wr_tim;

    hcfg_unlock_fsm #(
        .ADDR_W   (ADDR_W),
        .BYTE_W   (REG_W),
        .RD_OFS   (RD_OFS),
        .GATE_OFS (GATE_OFS),
        .OPEN_KEY (OPEN_KEY),
        .CLOSE_KEY(CLOSE_KEY)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_word (acc_word),
        .acc_addr (acc_addr),
        .acc_wbyte(acc_wbyte),
        .bank_open(bank_open),
        .key_hit  (key_hit)
    );

    assign cfg_wr   = bank_open && acc_valid && acc_write && !acc_word;
    assign arm_load = !bank_open && acc_valid && acc_write && !acc_word
                      && (acc_addr == ADDR_W'(ARM_OFS));

    hcfg_regbank #(
        .REG_W   (REG_W),
        .ADDR_W  (ADDR_W),
        .NUM_SETS(NUM_SETS),
        .TIM_RST ('0)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_idx  (acc_addr),
        .cfg_wdata(acc_wbyte),
        .arm_load (arm_load),
        .arm_value(acc_wbyte == REG_W'(ARM_KEY)),
        .strap_bit(strap_clk25),
        .cfg_rdata(cfg_rdata),
        .rd_tim   (rd_tim),
        .wr_tim   (wr_tim),
        .ctrl_q   (ctrl_reg),
        .misc_q   (misc_reg)
    );

    assign rd_timing = rd_tim;
    assign wr_timing = wr_tim;
    assign tf_sel    = acc_valid && !bank_open && !key_hit;

    always_comb begin
        if (!bank_open)   rdata = tf_rdata;
        else if (acc_word) rdata = '0;
        else              rdata = {{(DATA_W-REG_W){1'b0}}, cfg_rdata};
    end

endmodule

// File: rtl/hcfg_bank_chk.sv
module hcfg_bank_chk #(
    parameter int DATA_W   = 16,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 3,
    parameter int NUM_SETS = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_valid,
    input logic                      acc_write,
    input logic                      acc_word,
    input logic [ADDR_W-1:0]         acc_addr,
    input logic [REG_W-1:0]          acc_wbyte,
    input logic                      strap_clk25,
    input logic                      tf_sel,
    input logic [DATA_W-1:0]         rdata,
    input logic                      bank_open,
    input logic [NUM_SETS*REG_W-1:0] rd_timing,
    input logic [NUM_SETS*REG_W-1:0] wr_timing,
    input logic [REG_W-1:0]          ctrl_reg,
    input logic [REG_W-1:0]          misc_reg
);

    logic open_byte_rd;
    assign open_byte_rd = bank_open && acc_valid && !acc_write && !acc_word;

    p_open_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_open) |-> $past(acc_valid && acc_write && !acc_word
                                   && acc_addr == 3'd2 && acc_wbyte == 8'h03));

    p_close_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open && acc_valid && acc_write && !acc_word
         && acc_addr == 3'd2 && acc_wbyte == 8'h83) |=> !bank_open);

    p_no_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_open |-> !tf_sel);

    p_strap_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_byte_rd && acc_addr == 3'd5)
        |-> rdata == {{(DATA_W-1){1'b0}}, strap_clk25});

    p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (open_byte_rd && (acc_addr == 3'd2 || acc_addr == 3'd4 || acc_addr == 3'd7))
        |-> rdata == '0);

    p_locked_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_open |=> ($stable(rd_timing) && $stable(wr_timing)
                        && $stable(ctrl_reg) && $stable(misc_reg)));

endmodule

bind hcfg_bank hcfg_bank_chk #(
    .DATA_W  (DATA_W),
    .REG_W   (REG_W),
    .ADDR_W  (ADDR_W),
    .NUM_SETS(NUM_SETS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_word   (acc_word),
    .acc_addr   (acc_addr),
    .acc_wbyte  (acc_wbyte),
    .strap_clk25(strap_clk25),
    .tf_sel     (tf_sel),
    .rdata      (rdata),
    .bank_open  (bank_open),
    .rd_timing  (rd_timing),
    .wr_timing  (wr_timing),
    .ctrl_reg   (ctrl_reg),
    .misc_reg   (misc_reg)
);

// File: tb/hcfg_bank_tb.sv
module hcfg_bank_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, acc_word;
    logic [2:0]  acc_addr;
    logic [7:0]  acc_wbyte;
    logic [15:0] tf_rdata;
    logic        strap_clk25;
    logic        tf_sel;
    logic [15:0] rdata;
    logic        bank_open;
    logic [15:0] rd_timing, wr_timing;
    logic [7:0]  ctrl_reg, misc_reg;

    int checks = 0;
    int errors = 0;
    logic        done = 1'b0;
    logic [15:0] cap_rdata;
    logic        cap_tfsel;

    always #(CLK_PERIOD/2) clk = ~clk;

    hcfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_word(acc_word), .acc_addr(acc_addr), .acc_wbyte(acc_wbyte),
        .tf_rdata(tf_rdata), .strap_clk25(strap_clk25), .tf_sel(tf_sel),
        .rdata(rdata), .bank_open(bank_open), .rd_timing(rd_timing),
        .wr_timing(wr_timing), .ctrl_reg(ctrl_reg), .misc_reg(misc_reg)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access: drive after a falling edge, capture combinational outputs, commit on rising edge
    task automatic acc(input logic wr, input logic wd, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_word = wd; acc_addr = a; acc_wbyte = d;
        #1;
        cap_rdata = rdata;
        cap_tfsel = tf_sel;
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_write = 1'b0; acc_word = 1'b0;
    endtask

    task automatic unlock();
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b1, 1'b0, 3'd2, 8'h03);
    endtask

    task automatic relock();
        acc(1'b1, 1'b0, 3'd2, 8'h83);
    endtask

    task automatic t_reset();
        check("R1 bank closed", 16'(bank_open), 16'h0);
        check("R1 rd timing", rd_timing, 16'h0000);
        check("R1 wr timing", wr_timing, 16'h0000);
        check("R1 ctrl/misc", {ctrl_reg, misc_reg}, 16'h0000);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        check("R1 rdata passthrough", cap_rdata, 16'hA5A5);
        check("R5 closed forward", 16'(cap_tfsel), 16'h1);
    endtask

    task automatic t_unlock();
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        check("R5 seq read forwarded", 16'(cap_tfsel), 16'h1);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        check("R2 not open after two reads", 16'(bank_open), 16'h0);
        acc(1'b1, 1'b0, 3'd2, 8'h03);
        check("R2 key write not forwarded", 16'(cap_tfsel), 16'h0);
        check("R2 bank opened", 16'(bank_open), 16'h1);
    endtask

    task automatic t_cfg_a();
        acc(1'b1, 1'b0, 3'd0, 8'h3A);
        check("R5 open write not forwarded", 16'(cap_tfsel), 16'h0);
        acc(1'b1, 1'b0, 3'd1, 8'h5C);
        acc(1'b1, 1'b0, 3'd3, 8'h85);
        acc(1'b1, 1'b0, 3'd6, 8'h30);
        check("R6 rd timing A", rd_timing, 16'h003A);
        check("R6 wr timing A", wr_timing, 16'h005C);
        check("R6 ctrl/misc", {ctrl_reg, misc_reg}, 16'h8530);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        check("R6 read idx0", cap_rdata, 16'h003A);
        check("R5 open read not forwarded", 16'(cap_tfsel), 16'h0);
        acc(1'b0, 1'b0, 3'd1, 8'h00);
        check("R6 read idx1", cap_rdata, 16'h005C);
        acc(1'b0, 1'b0, 3'd3, 8'h00);
        check("R6 read idx3", cap_rdata, 16'h0085);
        acc(1'b0, 1'b0, 3'd6, 8'h00);
        check("R6 read idx6", cap_rdata, 16'h0030);
    endtask

    task automatic t_strap();
        strap_clk25 = 1'b1;
        acc(1'b0, 1'b0, 3'd5, 8'h00);
        check("R7 strap 25MHz", cap_rdata, 16'h0001);
        acc(1'b1, 1'b0, 3'd5, 8'hFF);
        strap_clk25 = 1'b0;
        acc(1'b0, 1'b0, 3'd5, 8'h00);
        check("R7 strap 33MHz after write", cap_rdata, 16'h0000);
    endtask

    task automatic t_undef();
        acc(1'b1, 1'b0, 3'd4, 8'h77);
        acc(1'b0, 1'b0, 3'd2, 8'h00);
        check("R8 idx2 reads zero", cap_rdata, 16'h0000);
        acc(1'b0, 1'b0, 3'd4, 8'h00);
        check("R8 idx4 reads zero", cap_rdata, 16'h0000);
        acc(1'b0, 1'b0, 3'd7, 8'h00);
        check("R8 idx7 reads zero", cap_rdata, 16'h0000);
        acc(1'b0, 1'b1, 3'd0, 8'h00);
        check("R8 word read zero", cap_rdata, 16'h0000);
        acc(1'b1, 1'b1, 3'd0, 8'hEE);
        check("R8 word write ignored", rd_timing, 16'h003A);
    endtask

    task automatic t_close();
        relock();
        check("R4 bank closed", 16'(bank_open), 16'h0);
        check("R4 close write not forwarded", 16'(cap_tfsel), 16'h0);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        check("R4 passthrough resumed", cap_rdata, 16'hA5A5);
        check("R5 forwarded after close", 16'(cap_tfsel), 16'h1);
    endtask

    task automatic t_locked();
        acc(1'b1, 1'b0, 3'd0, 8'hEE);
        acc(1'b1, 1'b0, 3'd6, 8'hEE);
        check("R11 rd timing unchanged", rd_timing, 16'h003A);
        check("R11 misc unchanged", 16'(misc_reg), 16'h0030);
    endtask

    task automatic t_broken();
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b0, 1'b0, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b1, 1'b0, 3'd2, 8'h03);
        check("R3 byte read breaks seq", 16'(bank_open), 16'h0);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b1, 1'b0, 3'd2, 8'h02);
        check("R3 wrong key", 16'(bank_open), 16'h0);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b1, 1'b0, 3'd2, 8'h03);
        check("R3 third read breaks seq", 16'(bank_open), 16'h0);
        acc(1'b0, 1'b1, 3'd1, 8'h00);
        acc(1'b1, 1'b0, 3'd2, 8'h03);
        check("R3 early key", 16'(bank_open), 16'h0);
        unlock();
        check("R3 recovers to idle", 16'(bank_open), 16'h1);
        relock();
    endtask

    task automatic t_setb();
        acc(1'b1, 1'b0, 3'd3, 8'h00);
        unlock();
        acc(1'b1, 1'b0, 3'd6, 8'h01);
        acc(1'b1, 1'b0, 3'd0, 8'h11);
        check("R10 unarmed hits set A", rd_timing, 16'h0011);
        relock();
        acc(1'b1, 1'b0, 3'd3, 8'hC0);
        check("R9 arm write forwarded", 16'(cap_tfsel), 16'h1);
        unlock();
        acc(1'b1, 1'b0, 3'd0, 8'h77);
        acc(1'b1, 1'b0, 3'd1, 8'h66);
        check("R9 armed rd set B", rd_timing, 16'h7711);
        check("R10 armed wr set B", wr_timing, 16'h665C);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        check("R10 read set B", cap_rdata, 16'h0077);
        acc(1'b1, 1'b0, 3'd6, 8'h00);
        acc(1'b0, 1'b0, 3'd0, 8'h00);
        check("R10 misc0 back to set A", cap_rdata, 16'h0011);
        relock();
        acc(1'b1, 1'b0, 3'd3, 8'h12);
        unlock();
        acc(1'b1, 1'b0, 3'd6, 8'h01);
        acc(1'b1, 1'b0, 3'd0, 8'h22);
        check("R9 disarmed by other write", rd_timing, 16'h7722);
        relock();
    endtask

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_word = 1'b0;
        acc_addr = '0; acc_wbyte = '0; tf_rdata = 16'hA5A5; strap_clk25 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlock();
        t_cfg_a();
        t_strap();
        t_undef();
        t_close();
        t_locked();
        t_broken();
        t_setb();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule